// File: doc/BRIEF.md
# 66-bit Block Lock Controller

This block sits on the receive side of a 64B/66B link, directly after the gearbox that cuts the serial stream into candidate 66-bit blocks. For each block it sees only the 2-bit sync header and a strobe. From those headers it judges whether the assumed block boundary is correct. When it is not, it asks the gearbox to move the boundary by one bit.

While the controller is unlocked, it hunts for a boundary at which headers keep validating, and it declares lock after an unbroken run of good headers. While it is locked, it tolerates scattered bit errors. It drops lock only when too many bad headers fall inside one fixed window of blocks. After every slip it discards the next strobed header, because that header may still straddle the old boundary. Downstream logic uses the lock flag to qualify decoding, and uses the per-block header-ok pulse to track block health.

Top module: `hdr_lock_ctrl`

## Requirements
- R1: A header value of 2'b01 (data) or 2'b10 (control) is valid, and 2'b00 or 2'b11 is invalid. Each accepted block with a valid header gives a `hdr_ok_o` pulse of one cycle, in the cycle after its strobe.
- R2: A cycle with `hdr_vld_i` low changes no counter and no state, and it gives no `slip_o` or `hdr_ok_o` pulse.
- R3: While unlocked, `lock_o` rises in the cycle after the strobe of the 64th consecutive accepted valid header, and not earlier.
- R4: While unlocked, an accepted invalid header restarts the good-header run from zero and gives exactly one `slip_o` pulse of one cycle.
- R5: After any slip, the next strobed block is ignored: it gives no `hdr_ok_o`, no slip and no count. The block after it is judged normally.
- R6: While locked, the 16th accepted invalid header within the current window clears `lock_o` in the next cycle and gives one `slip_o` pulse. The hunt then starts over with all counters at zero.
- R7: While locked, blocks are grouped into windows of 64 accepted blocks, counted from the moment of lock. At the end of each window the invalid-header count restarts, so 15 bad headers in each of successive windows never drop lock.
- R8: If the 16th bad header of a window is also the window's 64th block, lock is lost. The loss takes precedence over the window restart.
- R9: Reset (`rst_ni` low) forces `lock_o`, `slip_o` and `hdr_ok_o` low, puts the controller in the hunt phase with no pending skip, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_i | input | 2 | Sync header of the candidate block |
| hdr_vld_i | input | 1 | Strobe: `hdr_i` holds a new block header |
| lock_o | output | 1 | Block lock achieved |
| slip_o | output | 1 | One-cycle request to shift the block boundary by one bit |
| hdr_ok_o | output | 1 | One-cycle pulse: the accepted block had a valid header |

## Verification
Two events can fall on the same block: the close of a 64-block window and the 16th bad header of that window. The bench provokes this by relocking and then sending 48 good headers followed by 16 bad ones. It judges the result by whether lock falls, whether a slip pulse appears and whether the following block is skipped. A correct design drops lock here, and a design that restarts the window first stays locked. The behavioural reference model, compared on every clock, also meets this case and the case of a window closing with only 15 errors during long randomised runs.

// File: rtl/hdr_lock_pkg.sv
package hdr_lock_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lock_st_e;

  localparam logic [1:0] HDR_DATA = 2'b01;
  localparam logic [1:0] HDR_CTRL = 2'b10;

  function automatic logic hdr_is_sync(input logic [1:0] h);
    return (h == HDR_DATA) || (h == HDR_CTRL);
  endfunction

endpackage

// File: rtl/hdr_classify.sv
module hdr_classify
  import hdr_lock_pkg::*;
(
  input  logic [1:0] hdr_i,
  input  logic       vld_i,
  input  logic       skip_i,
  output logic       acc_o,
  output logic       good_o,
  output logic       bad_o
);

  logic sync;

  assign sync   = hdr_is_sync(hdr_i);
  assign acc_o  = vld_i & ~skip_i;
  assign good_o = acc_o & sync;
  assign bad_o  = acc_o & ~sync;

endmodule

// File: rtl/blk_counter.sv
module blk_counter #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;

  // last_o flags the increment that completes LIMIT counts; counter wraps
  assign last_o = inc_i & (cnt_q == TOP);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (last_o) cnt_d = '0;
    else if (inc_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import hdr_lock_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     vld_i,
  input  logic     good_i,
  input  logic     bad_i,
  input  logic     run_hit_i,
  input  logic     err_hit_i,
  output lock_st_e st_o,
  output logic     skip_o,
  output logic     slip_o,
  output logic     ok_o
);

  lock_st_e st_q, st_d;
  logic     skip_q, skip_d;
  logic     slip_q, slip_d;
  logic     ok_q;

  always_comb begin
    st_d   = st_q;
    slip_d = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (bad_i)       slip_d = 1'b1;
        else if (good_i) st_d = run_hit_i ? ST_LOCKED : ST_VERIFY;
      end
      ST_VERIFY: begin
        if (bad_i) begin
          st_d   = ST_HUNT;
          slip_d = 1'b1;
        end else if (run_hit_i) begin
          st_d = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        if (err_hit_i) begin
          st_d   = ST_HUNT;
          slip_d = 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  // the first strobe after a slip may still straddle the old boundary
  always_comb begin
    skip_d = skip_q;
    if (slip_d)     skip_d = 1'b1;
    else if (vld_i) skip_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      skip_q <= 1'b0;
      slip_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      skip_q <= skip_d;
      slip_q <= slip_d;
      ok_q   <= good_i;
    end
  end

  assign st_o   = st_q;
  assign skip_o = skip_q;
  assign slip_o = slip_q;
  assign ok_o   = ok_q;

endmodule

// File: rtl/hdr_lock_ctrl.sv
module hdr_lock_ctrl
  import hdr_lock_pkg::*;
#(
  parameter int LOCK_RUN = 64,
  parameter int WIN_LEN  = 64,
  parameter int ERR_MAX  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] hdr_i,
  input  logic       hdr_vld_i,
  output logic       lock_o,
  output logic       slip_o,
  output logic       hdr_ok_o
);

  lock_st_e st;
  logic     locked;
  logic     skip;
  logic     acc, good, bad;
  logic     run_hit, win_hit, err_hit;

  assign locked = (st == ST_LOCKED);

  hdr_classify u_cls (
    .hdr_i  (hdr_i),
    .vld_i  (hdr_vld_i),
    .skip_i (skip),
    .acc_o  (acc),
    .good_o (good),
    .bad_o  (bad)
  );

  // unbroken run of good headers while hunting
  blk_counter #(.LIMIT(LOCK_RUN)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bad | locked),
    .inc_i  (good & ~locked),
    .last_o (run_hit)
  );

  // fixed window of accepted blocks while locked
  blk_counter #(.LIMIT(WIN_LEN)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~locked),
    .inc_i  (acc & locked),
    .last_o (win_hit)
  );

  // bad headers inside the current window
  blk_counter #(.LIMIT(ERR_MAX)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~locked | (win_hit & ~err_hit)),
    .inc_i  (bad & locked),
    .last_o (err_hit)
  );

  lock_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vld_i     (hdr_vld_i),
    .good_i    (good),
    .bad_i     (bad),
    .run_hit_i (run_hit),
    .err_hit_i (err_hit),
    .st_o      (st),
    .skip_o    (skip),
    .slip_o    (slip_o),
    .ok_o      (hdr_ok_o)
  );

  assign lock_o = locked;

endmodule

// File: rtl/hdr_lock_chk.sv
module hdr_lock_chk
  import hdr_lock_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] hdr_i,
  input logic       hdr_vld_i,
  input logic       lock_o,
  input logic       slip_o,
  input logic       hdr_ok_o
);

  AST_OK_NEEDS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ok_o |-> ($past(hdr_vld_i) && hdr_is_sync($past(hdr_i)))); // R1

  AST_IDLE_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_vld_i |=> (!hdr_ok_o && !slip_o && $stable(lock_o))); // R2

  AST_LOCK_ON_GOOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> ($past(hdr_vld_i) && hdr_is_sync($past(hdr_i)) && !slip_o)); // R3

  AST_SLIP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o); // R4

  AST_SLIP_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> !lock_o); // R4

  AST_UNLOCK_ON_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_o) |-> (slip_o && $past(hdr_vld_i) && !hdr_is_sync($past(hdr_i)))); // R6

endmodule

bind hdr_lock_ctrl hdr_lock_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hdr_i     (hdr_i),
  .hdr_vld_i (hdr_vld_i),
  .lock_o    (lock_o),
  .slip_o    (slip_o),
  .hdr_ok_o  (hdr_ok_o)
);

// File: tb/hdr_lock_ctrl_tb.sv
`timescale 1ns/1ps
module hdr_lock_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] hdr = 2'b00;
  logic       vld = 1'b0;
  logic       lock_o, slip_o, hdr_ok_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  hdr_lock_ctrl u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .hdr_i     (hdr),
    .hdr_vld_i (vld),
    .lock_o    (lock_o),
    .slip_o    (slip_o),
    .hdr_ok_o  (hdr_ok_o)
  );

  // behavioural reference
  int m_lock, m_good, m_win, m_bad, m_skip, e_slip, e_ok;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_good = 0; m_win = 0; m_bad = 0; m_skip = 0;
      e_slip = 0; e_ok = 0;
    end else begin
      e_slip = 0; e_ok = 0;
      if (vld) begin
        if (m_skip != 0) begin
          m_skip = 0;
        end else begin
          e_ok = (hdr == 2'b01 || hdr == 2'b10) ? 1 : 0;
          if (m_lock == 0) begin
            if (e_ok != 0) begin
              m_good++;
              if (m_good == 64) begin
                m_lock = 1; m_good = 0; m_win = 0; m_bad = 0;
              end
            end else begin
              m_good = 0; e_slip = 1; m_skip = 1;
            end
          end else begin
            m_win++;
            if (e_ok == 0) m_bad++;
            if (m_bad == 16) begin
              m_lock = 0; m_good = 0; m_win = 0; m_bad = 0;
              e_slip = 1; m_skip = 1;
            end else if (m_win == 64) begin
              m_win = 0; m_bad = 0;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (lock_o !== m_lock[0]) begin
        n_fail++;
        $display("FAIL R3 lock_o t=%0t act=%0b exp=%0d", $time, lock_o, m_lock);
      end
      if (slip_o !== e_slip[0]) begin
        n_fail++;
        $display("FAIL R4 slip_o t=%0t act=%0b exp=%0d", $time, slip_o, e_slip);
      end
      if (hdr_ok_o !== e_ok[0]) begin
        n_fail++;
        $display("FAIL R1 hdr_ok_o t=%0t act=%0b exp=%0d", $time, hdr_ok_o, e_ok);
      end
    end
  end

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] h);
    hdr = h; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic idle(input int n);
    vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic get_lock();
    if (m_skip != 0) send(2'b10);
    for (int i = 0; i < 64; i++) send((i % 2 == 0) ? 2'b01 : 2'b10);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(lock_o == 0 && slip_o == 0 && hdr_ok_o == 0, "R9 reset outputs", lock_o, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 lock after exactly 64, R2 idle gaps do not break the run
    for (int i = 0; i < 63; i++) send(2'b01);
    chk(lock_o == 0, "R3 no lock after 63", lock_o, 0);
    idle(20);
    chk(lock_o == 0 && hdr_ok_o == 0, "R2 idle keeps state", lock_o, 0);
    send(2'b10);
    chk(lock_o == 1, "R3 lock on 64th", lock_o, 1);
    chk(hdr_ok_o == 1, "R1 ok pulse", hdr_ok_o, 1);

    // R7 15 bad per window never drops lock
    for (int w = 0; w < 3; w++)
      for (int i = 0; i < 64; i++) send((i % 4 == 1 && i < 60) ? 2'b11 : 2'b01);
    chk(lock_o == 1, "R7 window restart keeps lock", lock_o, 1);

    // R6 16 bad in one window drop lock
    for (int i = 0; i < 15; i++) send(2'b00);
    chk(lock_o == 1, "R6 still locked at 15", lock_o, 1);
    send(2'b11);
    chk(lock_o == 0, "R6 unlock on 16th", lock_o, 0);
    chk(slip_o == 1, "R6 slip on unlock", slip_o, 1);

    // R5 block after slip ignored
    send(2'b00);
    chk(slip_o == 0 && hdr_ok_o == 0, "R5 ignored after slip", slip_o, 0);
    send(2'b01);
    chk(hdr_ok_o == 1, "R5 next block judged", hdr_ok_o, 1);

    // R4 bad while hunting restarts run
    for (int i = 0; i < 40; i++) send(2'b01);
    send(2'b11);
    chk(slip_o == 1, "R4 slip on bad", slip_o, 1);
    idle(1);
    chk(slip_o == 0, "R4 slip single cycle", slip_o, 0);
    send(2'b01);
    for (int i = 0; i < 63; i++) send(2'b10);
    chk(lock_o == 0, "R4 run restarted", lock_o, 0);
    send(2'b10);
    chk(lock_o == 1, "R4 lock after fresh 64", lock_o, 1);

    // R8 16th bad on 64th block of window
    for (int i = 0; i < 64; i++) send(2'b01);
    for (int i = 0; i < 48; i++) send(2'b10);
    for (int i = 0; i < 15; i++) send(2'b00);
    chk(lock_o == 1, "R8 locked before coincident block", lock_o, 1);
    send(2'b11);
    chk(lock_o == 0 && slip_o == 1, "R8 unlock beats window restart", lock_o, 0);

    // randomised mixes, compared per cycle by the model
    for (int phase = 0; phase < 4; phase++) begin
      get_lock();
      for (int i = 0; i < 3000; i++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 15) idle(1);
        else begin
          int lim;
          lim = (phase % 2 == 0) ? 3 : 20;
          send(($urandom_range(0, 99) < lim) ? 2'($urandom_range(0, 1) * 3) :
               2'($urandom_range(1, 2)));
        end
      end
    end

    // R9 mid-run reset
    get_lock();
    rst_n = 1'b0;
    #3;
    chk(lock_o == 0 && slip_o == 0 && hdr_ok_o == 0, "R9 async reset", lock_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 63; i++) send(2'b01);
    chk(lock_o == 0, "R9 counters cleared", lock_o, 0);
    send(2'b01);
    chk(lock_o == 1, "R9 relock after reset", lock_o, 1);
    idle(4);
    finish_run();
  end

endmodule